// File: doc/BRIEF.md
# SDRAM Burst Write Sequencer

This block sits on the controller side of a synchronous DRAM port with a 32-bit data bus. It carries out one 32-byte write at a time. A request brings a row, a bank, a word-granular column and eight data words. The sequencer then drives the command pins, the bank and address lines, the byte masks and the write data. It also gives a DMA acknowledge strobe. Each 32-byte block is written as two bursts of four words. The first burst uses a plain write command. The second burst, issued four cycles later, uses a write with auto-precharge.

The transfer begins at the 16-byte half of the 32-byte block that holds the requested column. It then wraps to the other half. After the last data word, the sequencer holds off any new command for a write-recovery interval and then a precharge interval. Both lengths come from 3-bit configuration inputs that are captured when the request is accepted. The request side uses a valid/ready handshake. A single-cycle done pulse marks the final wait cycle.

Top module: `sdram_burst_writer`

## Requirements
- R1: During and right after synchronous reset, req_ready is 1, done and dma_ack are 0, the data bus is not driven (sd_dq_oe 0, sd_dq_out 0), every byte mask is 1, and chip select, RAS#, CAS# and WE# are all high with bank and address 0.
- R2: dma_ack is high for exactly one cycle. That cycle is the first cycle after acceptance (valid and ready both high at a clock edge), which is two cycles before the first write command.
- R3: In the second cycle after acceptance, the bank-activate command is driven: CS# 0, RAS# 0, CAS# 1, WE# 1. It carries the request bank and puts the row on sd_addr.
- R4: The cycle right after activate carries a plain write: CS# 0, RAS# 1, CAS# 0, WE# 0, address bit 10 low. The column is {col[COL_W-1:3], col[2], 2'b00}, the first word of the half that holds the requested column.
- R5: Exactly four cycles after the plain write, a write with auto-precharge is driven on the same bank. It uses the same pin encoding as the plain write but with address bit 10 high, and the column is {col[COL_W-1:3], ~col[2], 2'b00}.
- R6: Data beats occupy the eight cycles that start with the plain write. Beat b (0 to 7) drives request word ((4*col[2] + b) mod 8), where word i sits at req_words[i*32 +: 32]. During the beats sd_dq_oe is 1 and all byte masks are 0. Outside the beats the masks are all 1, sd_dq_oe is 0 and sd_dq_out is 0.
- R7: In every busy cycle other than activate and the two write commands, CS#, RAS#, CAS# and WE# are all high and bank and address are 0.
- R8: After the last data beat there follow cfg_rwl write-recovery cycles (0 to 7), then max(cfg_pc, 1) precharge cycles, with no command issued. req_ready stays 0 from acceptance through the last of these cycles.
- R9: done is high for exactly one cycle, the last precharge cycle. req_ready is 1 in the cycle that follows.
- R10: Row, bank, column, data words and both configuration fields are captured at acceptance. Changes to them, and a held req_valid, while the block is busy have no effect on the running transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle, request accepted when valid |
| req_row | input | ADDR_W | Row to activate |
| req_bank | input | BANK_W | Target bank |
| req_col | input | COL_W | Word column inside the row |
| req_words | input | 8*DATA_W | Eight data words, word i at bits i*DATA_W upward |
| cfg_rwl | input | 3 | Write-recovery wait cycles |
| cfg_pc | input | 3 | Precharge wait cycles, 0 treated as 1 |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_bank | output | BANK_W | Bank select |
| sd_addr | output | ADDR_W | Row or column address, bit 10 selects auto-precharge |
| sd_dqm | output | DATA_W/8 | Byte masks, 1 masks a byte |
| sd_dq_out | output | DATA_W | Write data |
| sd_dq_oe | output | 1 | Data bus output enable |
| dma_ack | output | 1 | DMA acknowledge strobe |
| done | output | 1 | Last wait cycle of a transfer |

## Verification
Two functions share a cycle at the start of each burst: a write command and its first data word appear on the pins together. The same holds later, when the auto-precharge write coincides with beat four, whose column must point at the opposite half. Both are provoked by sweeping both halves of the block through every write-recovery and precharge setting, and they are judged by comparing the full pin vector each cycle against a trace computed from the requirements. A second coincidence is done falling on the single precharge cycle when cfg_pc is 0 or 1. The bench judges this by confirming that ready returns exactly one cycle later, even though req_valid has been held high and the inputs scrambled throughout.

// File: rtl/sbw_pkg.sv
// Package: shared types for the SDRAM burst write sequencer.
// Assumes a fixed burst of four words and two bursts per 32-byte block.
package sbw_pkg;
    localparam int BURST_LEN = 4;
    localparam int BEATS     = 2 * BURST_LEN;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LEAD,
        ST_ACT,
        ST_DATA,
        ST_RWL,
        ST_PC
    } sbw_state_t;

    typedef enum logic [1:0] {
        CMD_NOP,
        CMD_ACT,
        CMD_WR,
        CMD_WRA
    } sbw_cmd_t;
endpackage

// File: rtl/sbw_seq.sv
// Module: sbw_seq
// Phase sequencer. It steps through lead, activate, eight data beats,
// write recovery and precharge wait, and produces the abstract command,
// the beat index, the acknowledge, done and ready.
// Assumes start is only asserted while ready is high.
module sbw_seq
    import sbw_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic [2:0] cfg_rwl,
    input  logic [2:0] cfg_pc,
    output sbw_cmd_t   cmd,
    output logic [2:0] beat,
    output logic       beat_valid,
    output logic       ack,
    output logic       done,
    output logic       ready
);
    localparam logic [2:0] LAST_BEAT = 3'(BEATS - 1);
    localparam logic [2:0] WRA_BEAT  = 3'(BURST_LEN);

    sbw_state_t state_q, state_d;
    logic [2:0] cnt_q, cnt_d;
    logic [2:0] rwl_q, pc_q;
    logic [2:0] pc_last;

    // Last index of the precharge wait; a zero setting still waits one cycle.
    assign pc_last = (pc_q == 3'd0) ? 3'd0 : pc_q - 3'd1;

    // Capture the wait configuration when a request is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rwl_q <= '0;
            pc_q  <= '0;
        end else if (start) begin
            rwl_q <= cfg_rwl;
            pc_q  <= cfg_pc;
        end
    end

    // Next-state and counter logic for the phase machine.
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_IDLE: if (start) state_d = ST_LEAD;
            ST_LEAD: state_d = ST_ACT;
            ST_ACT: begin
                state_d = ST_DATA;
                cnt_d   = '0;
            end
            ST_DATA: begin
                cnt_d = cnt_q + 3'd1;
                if (cnt_q == LAST_BEAT) begin
                    state_d = (rwl_q != 3'd0) ? ST_RWL : ST_PC;
                    cnt_d   = '0;
                end
            end
            ST_RWL: begin
                cnt_d = cnt_q + 3'd1;
                if (cnt_q == rwl_q - 3'd1) begin
                    state_d = ST_PC;
                    cnt_d   = '0;
                end
            end
            ST_PC: begin
                cnt_d = cnt_q + 3'd1;
                if (cnt_q == pc_last) begin
                    state_d = ST_IDLE;
                    cnt_d   = '0;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State and counter registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Decode the abstract command and strobes from the phase.
    always_comb begin
        cmd = CMD_NOP;
        if (state_q == ST_ACT) cmd = CMD_ACT;
        else if (state_q == ST_DATA && cnt_q == 3'd0) cmd = CMD_WR;
        else if (state_q == ST_DATA && cnt_q == WRA_BEAT) cmd = CMD_WRA;
    end

    assign beat       = (state_q == ST_DATA) ? cnt_q : 3'd0;
    assign beat_valid = (state_q == ST_DATA);
    assign ack        = (state_q == ST_LEAD);
    assign done       = (state_q == ST_PC) && (cnt_q == pc_last);
    assign ready      = (state_q == ST_IDLE);

    // R2: acceptance is followed by the acknowledge cycle.
    assert_accept_ack_R2: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> ack);
    // R9: done lasts one cycle and ready follows it.
    assert_done_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (ready && !done));
endmodule

// File: rtl/sbw_beat.sv
// Module: sbw_beat
// Payload holder and beat multiplexer. It captures row, bank, column and
// eight words at load, then produces the address, bank, data, masks and
// output enable for each abstract command and beat.
// Assumes COL_W is at least 4 and does not reach the auto-precharge bit.
module sbw_beat
    import sbw_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 13,
    parameter int BANK_W = 2,
    parameter int COL_W  = 9,
    parameter int AP_BIT = 10
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    load,
    input  logic [ADDR_W-1:0]       row_i,
    input  logic [BANK_W-1:0]       bank_i,
    input  logic [COL_W-1:0]        col_i,
    input  logic [BEATS*DATA_W-1:0] words_i,
    input  sbw_cmd_t                cmd,
    input  logic [2:0]              beat,
    input  logic                    beat_valid,
    output logic [ADDR_W-1:0]       addr_o,
    output logic [BANK_W-1:0]       bank_o,
    output logic [DATA_W-1:0]       data_o,
    output logic                    oe_o,
    output logic [DATA_W/8-1:0]     dqm_o
);
    localparam int MASK_W = DATA_W / 8;

    logic [ADDR_W-1:0]       row_q;
    logic [BANK_W-1:0]       bank_q;
    logic [COL_W-1:0]        col_q;
    logic [BEATS*DATA_W-1:0] words_q;
    logic [DATA_W-1:0]       word_arr [BEATS];
    logic                    half;
    logic [2:0]              word_idx;
    logic [COL_W-1:0]        col_first, col_second;

    // Capture the request payload at acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row_q   <= '0;
            bank_q  <= '0;
            col_q   <= '0;
            words_q <= '0;
        end else if (load) begin
            row_q   <= row_i;
            bank_q  <= bank_i;
            col_q   <= col_i;
            words_q <= words_i;
        end
    end

    // Split the flat word bus into an indexable array.
    for (genvar gi = 0; gi < BEATS; gi++) begin : g_word
        assign word_arr[gi] = words_q[gi*DATA_W +: DATA_W];
    end

    assign half       = col_q[2];
    assign word_idx   = {half, 2'b00} + beat;
    assign col_first  = {col_q[COL_W-1:3], half, 2'b00};
    assign col_second = {col_q[COL_W-1:3], ~half, 2'b00};

    // Select the address and bank for the current command.
    always_comb begin
        addr_o = '0;
        bank_o = '0;
        unique case (cmd)
            CMD_ACT: begin
                addr_o = row_q;
                bank_o = bank_q;
            end
            CMD_WR: begin
                addr_o = ADDR_W'(col_first);
                bank_o = bank_q;
            end
            CMD_WRA: begin
                addr_o         = ADDR_W'(col_second);
                addr_o[AP_BIT] = 1'b1;
                bank_o         = bank_q;
            end
            default: ;
        endcase
    end

    assign data_o = beat_valid ? word_arr[word_idx] : '0;
    assign oe_o   = beat_valid;
    assign dqm_o  = beat_valid ? '0 : {MASK_W{1'b1}};
endmodule

// File: rtl/sdram_burst_writer.sv
// Module: sdram_burst_writer
// Top of the 32-byte SDRAM burst write sequencer. It joins the phase
// sequencer and the beat multiplexer and encodes commands onto the pins.
// Assumes burst length four is programmed in the device and the bus is
// owned by this block whenever req_ready is low.
module sdram_burst_writer
    import sbw_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 13,
    parameter int BANK_W = 2,
    parameter int COL_W  = 9,
    parameter int AP_BIT = 10
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_valid,
    output logic                    req_ready,
    input  logic [ADDR_W-1:0]       req_row,
    input  logic [BANK_W-1:0]       req_bank,
    input  logic [COL_W-1:0]        req_col,
    input  logic [8*DATA_W-1:0]     req_words,
    input  logic [2:0]              cfg_rwl,
    input  logic [2:0]              cfg_pc,
    output logic                    sd_cs_n,
    output logic                    sd_ras_n,
    output logic                    sd_cas_n,
    output logic                    sd_we_n,
    output logic [BANK_W-1:0]       sd_bank,
    output logic [ADDR_W-1:0]       sd_addr,
    output logic [DATA_W/8-1:0]     sd_dqm,
    output logic [DATA_W-1:0]       sd_dq_out,
    output logic                    sd_dq_oe,
    output logic                    dma_ack,
    output logic                    done
);
    sbw_cmd_t   cmd;
    logic [2:0] beat;
    logic       beat_valid;
    logic       start;

    assign start = req_valid && req_ready;

    sbw_seq u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .cfg_rwl    (cfg_rwl),
        .cfg_pc     (cfg_pc),
        .cmd        (cmd),
        .beat       (beat),
        .beat_valid (beat_valid),
        .ack        (dma_ack),
        .done       (done),
        .ready      (req_ready)
    );

    sbw_beat #(
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W),
        .BANK_W (BANK_W),
        .COL_W  (COL_W),
        .AP_BIT (AP_BIT)
    ) u_beat (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (start),
        .row_i      (req_row),
        .bank_i     (req_bank),
        .col_i      (req_col),
        .words_i    (req_words),
        .cmd        (cmd),
        .beat       (beat),
        .beat_valid (beat_valid),
        .addr_o     (sd_addr),
        .bank_o     (sd_bank),
        .data_o     (sd_dq_out),
        .oe_o       (sd_dq_oe),
        .dqm_o      (sd_dqm)
    );

    // Encode the abstract command onto the active-low command pins.
    always_comb begin
        {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = 4'b1111;
        unique case (cmd)
            CMD_ACT:         {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = 4'b0011;
            CMD_WR, CMD_WRA: {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = 4'b0100;
            default: ;
        endcase
    end

    // R3: the acknowledge cycle is followed by bank activate.
    assert_ack_then_act_R3: assert property (@(posedge clk) disable iff (!rst_n)
        dma_ack |=> (!sd_cs_n && !sd_ras_n && sd_cas_n && sd_we_n));
    // R4: activate is followed by a plain write with bit 10 low.
    assert_act_then_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!sd_cs_n && !sd_ras_n) |=> (!sd_cs_n && !sd_cas_n && !sd_we_n && !sd_addr[AP_BIT]));
    // R5: a plain write is followed four cycles later by auto-precharge write.
    assert_write_then_wra_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!sd_cs_n && !sd_cas_n && !sd_addr[AP_BIT]) |-> ##4
        (!sd_cs_n && !sd_cas_n && !sd_we_n && sd_addr[AP_BIT]));
    // R6: every write command comes with driven, unmasked data.
    assert_write_has_data_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!sd_cs_n && !sd_cas_n) |-> (sd_dq_oe && sd_dqm == '0));
    // R8: no request is accepted while a command or wait is in progress.
    assert_busy_not_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (sd_dq_oe || dma_ack) |-> !req_ready);
endmodule

// File: tb/sdram_burst_writer_tb.sv
// Bench: sweeps both start halves across all write-recovery and precharge
// settings and compares the full pin vector each cycle with a computed trace.
module sdram_burst_writer_tb_top;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 13;
    localparam int BANK_W = 2;
    localparam int COL_W  = 9;
    localparam int MASK_W = DATA_W / 8;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                req_valid = 1'b0;
    logic                req_ready;
    logic [ADDR_W-1:0]   req_row = '0;
    logic [BANK_W-1:0]   req_bank = '0;
    logic [COL_W-1:0]    req_col = '0;
    logic [8*DATA_W-1:0] req_words = '0;
    logic [2:0]          cfg_rwl = '0;
    logic [2:0]          cfg_pc = '0;
    logic                sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n;
    logic [BANK_W-1:0]   sd_bank;
    logic [ADDR_W-1:0]   sd_addr;
    logic [MASK_W-1:0]   sd_dqm;
    logic [DATA_W-1:0]   sd_dq_out;
    logic                sd_dq_oe;
    logic                dma_ack;
    logic                done;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    sdram_burst_writer #(
        .DATA_W (DATA_W), .ADDR_W (ADDR_W), .BANK_W (BANK_W), .COL_W (COL_W), .AP_BIT (10)
    ) dut_i (
        .clk (clk), .rst_n (rst_n), .req_valid (req_valid), .req_ready (req_ready),
        .req_row (req_row), .req_bank (req_bank), .req_col (req_col), .req_words (req_words),
        .cfg_rwl (cfg_rwl), .cfg_pc (cfg_pc),
        .sd_cs_n (sd_cs_n), .sd_ras_n (sd_ras_n), .sd_cas_n (sd_cas_n), .sd_we_n (sd_we_n),
        .sd_bank (sd_bank), .sd_addr (sd_addr), .sd_dqm (sd_dqm), .sd_dq_out (sd_dq_out),
        .sd_dq_oe (sd_dq_oe), .dma_ack (dma_ack), .done (done)
    );

    // Compare one cycle of pins against the expected fields.
    task automatic check_pins(input string tag, input logic [3:0] e_cmd, input logic e_ack,
                              input logic e_done, input logic e_rdy, input logic e_oe,
                              input logic [MASK_W-1:0] e_dqm, input logic [BANK_W-1:0] e_bank,
                              input logic [ADDR_W-1:0] e_addr, input logic [DATA_W-1:0] e_data);
        logic [3:0] a_cmd;
        a_cmd = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
        checks++;
        if (a_cmd !== e_cmd || dma_ack !== e_ack || done !== e_done || req_ready !== e_rdy ||
            sd_dq_oe !== e_oe || sd_dqm !== e_dqm || sd_bank !== e_bank ||
            sd_addr !== e_addr || sd_dq_out !== e_data) begin
            fails++;
            $display("FAIL %s: got cmd=%b ack=%b done=%b rdy=%b oe=%b dqm=%h bank=%h addr=%h data=%h, expected cmd=%b ack=%b done=%b rdy=%b oe=%b dqm=%h bank=%h addr=%h data=%h",
                     tag, a_cmd, dma_ack, done, req_ready, sd_dq_oe, sd_dqm, sd_bank, sd_addr, sd_dq_out,
                     e_cmd, e_ack, e_done, e_rdy, e_oe, e_dqm, e_bank, e_addr, e_data);
        end
    endtask

    // One transfer: drive the request, then check every cycle until idle.
    task automatic run_txn(input int txn, input logic h, input int rwl, input int pc);
        logic [ADDR_W-1:0]   row;
        logic [BANK_W-1:0]   bank;
        logic [COL_W-1:0]    col;
        logic [8*DATA_W-1:0] words;
        int pc_eff, total, b, idx;
        logic [ADDR_W-1:0] e_addr;
        row  = ADDR_W'((txn * 101 + 7) % 8192);
        bank = BANK_W'(txn % 4);
        col  = COL_W'((txn * 37) % 512);
        col[2] = h;
        for (int i = 0; i < 8; i++)
            words[i*DATA_W +: DATA_W] = 32'hA500_0000 + 32'(txn * 256 + i * 17);
        pc_eff = (pc == 0) ? 1 : pc;
        total  = 10 + rwl + pc_eff;

        @(negedge clk);
        req_row = row; req_bank = bank; req_col = col; req_words = words;
        cfg_rwl = 3'(rwl); cfg_pc = 3'(pc); req_valid = 1'b1;
        for (int k = 1; k <= total; k++) begin
            @(negedge clk);
            // R10: scramble inputs and keep valid high while busy.
            req_row = ~row; req_bank = ~bank; req_col = ~col; req_words = ~words;
            cfg_rwl = 3'(7 - rwl); cfg_pc = 3'(7 - pc);
            if (k == 1)
                check_pins("R2 ack", 4'b1111, 1'b1, 1'b0, 1'b0, 1'b0, '1, '0, '0, '0);
            else if (k == 2)
                check_pins("R3 activate", 4'b0011, 1'b0, 1'b0, 1'b0, 1'b0, '1, bank, row, '0);
            else if (k <= 10) begin
                b   = k - 3;
                idx = (4 * int'(h) + b) % 8;
                if (b == 0) begin
                    e_addr = ADDR_W'({col[COL_W-1:3], h, 2'b00});
                    check_pins("R4 R6 R10 write", 4'b0100, 1'b0, 1'b0, 1'b0, 1'b1, '0, bank,
                               e_addr, words[idx*DATA_W +: DATA_W]);
                end else if (b == 4) begin
                    e_addr = ADDR_W'({col[COL_W-1:3], ~h, 2'b00}) | ADDR_W'(1 << 10);
                    check_pins("R5 R6 R10 write-ap", 4'b0100, 1'b0, 1'b0, 1'b0, 1'b1, '0, bank,
                               e_addr, words[idx*DATA_W +: DATA_W]);
                end else
                    check_pins("R6 R7 R10 beat", 4'b1111, 1'b0, 1'b0, 1'b0, 1'b1, '0, '0, '0,
                               words[idx*DATA_W +: DATA_W]);
            end else if (k < total)
                check_pins("R7 R8 wait", 4'b1111, 1'b0, 1'b0, 1'b0, 1'b0, '1, '0, '0, '0);
            else begin
                check_pins("R8 R9 done", 4'b1111, 1'b0, 1'b1, 1'b0, 1'b0, '1, '0, '0, '0);
                req_valid = 1'b0;
            end
        end
        @(negedge clk);
        check_pins("R9 idle", 4'b1111, 1'b0, 1'b0, 1'b1, 1'b0, '1, '0, '0, '0);
    endtask

    initial begin
        int txn;
        txn = 0;
        repeat (3) @(negedge clk);
        // R1: reset state with reset still asserted.
        check_pins("R1 reset", 4'b1111, 1'b0, 1'b0, 1'b1, 1'b0, '1, '0, '0, '0);
        rst_n = 1'b1;
        @(negedge clk);
        check_pins("R1 after reset", 4'b1111, 1'b0, 1'b0, 1'b1, 1'b0, '1, '0, '0, '0);
        for (int h = 0; h < 2; h++)
            for (int rwl = 0; rwl < 8; rwl++)
                for (int pc = 0; pc < 8; pc++) begin
                    run_txn(txn, 1'(h), rwl, pc);
                    txn++;
                end
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: got no completion, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule